// File: doc/BRIEF.md
# Windowed Receive Buffer with Count Acknowledge

This block holds received serial bytes in a circular byte store and lets a 32-bit memory-mapped host read them in place. Rather than popping one byte per read from a data register, the host reads a fill count from the status word. It then copies bytes straight out of a readable window, where the first window byte is always the oldest unread byte. When it has finished, it writes the number of bytes it consumed to an acknowledge register, and that releases them. The serial deserializer is not part of the block. Each received byte arrives on a one-cycle byte-valid strobe.

Two interrupt causes come out of the block. The data-available cause stays high while the fill level is at or above a programmable trigger level. The character-timeout cause fires when some data is waiting below that level and no byte has arrived for a programmed number of baud ticks. A byte that arrives while the store is full is discarded, and a sticky overrun flag records the loss.

Top module: `rx_window_fifo`

## Requirements
- R1: After reset the fill count is 0, the overrun, data-available and timeout flags are clear, and the trigger-code and timeout registers read 0.
- R2: A byte strobed on `rx_valid_i` into a store that is not full is appended, and the fill count rises by one on the next cycle. The status word (offset 0x000) carries count bits 7:0 in bits 31:24 and count bits 9:8 in bits 7:6.
- R3: A read of window offset 4+4m (4 ≤ offset < 2^DEPTH_LOG2) returns, in byte lane j (bits 8j+7:8j), the unread byte at position 4m+j counted from the oldest. The data is on `bus_rdata_o` one cycle after the read strobe.
- R4: A write of n (wdata bits 9:0) to offset 0x800 releases the n oldest bytes: the count drops by n and the window then starts at the byte that followed them, with storage wrapping modulo 2^DEPTH_LOG2.
- R5: An acknowledge larger than the fill count releases exactly the fill count, and the count becomes 0.
- R6: The store holds at most 2^DEPTH_LOG2−1 bytes. A byte arriving when it is full is dropped and leaves the count and the data unchanged. It also sets a sticky overrun flag (`ovr_o`, status bit 0), which only a status write with bit 0 set clears.
- R7: The trigger code sits in bits 22:20 of the configuration register at 0x808, and the threshold is 4<<code bytes. `rda_o` and status bit 1 are high exactly while the count is at or above the threshold.
- R8: The timeout register at 0x814 (bits 15:0) holds T. While 0 < count < threshold, the timeout flag (`cti_o`, status bit 2) sets on the T-th `baud_tick_i` pulse after the last byte arrival or acknowledge. T = 0 disables it, and no timeout occurs at or above the threshold.
- R9: The timeout flag clears on a byte arrival, on an acknowledge write, or on a status write with bit 2 set.
- R10: The configuration and timeout registers read back what was written. A read of any other address (window beyond the store, unmapped offsets) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe: a received byte is present |
| rx_data_i | input | 8 | Received byte |
| baud_tick_i | input | 1 | One pulse per idle-timeout time unit |
| bus_addr_i | input | 12 | Host byte address |
| bus_wr_i | input | 1 | Host write strobe |
| bus_rd_i | input | 1 | Host read strobe |
| bus_wdata_i | input | 32 | Host write data |
| bus_rdata_o | output | 32 | Host read data, valid the cycle after the read strobe |
| rda_o | output | 1 | Data-available cause |
| cti_o | output | 1 | Character-timeout cause |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check the count on every cycle. It holds still when nothing arrives and nothing is acknowledged. It steps by exactly one per accepted byte and drops by exactly the acknowledged amount. A clamped acknowledge empties it, and a full store drops bytes and sets a sticky overrun. A rising timeout flag is also checked to be a level that was strictly below the trigger. Only the bench scenarios can show the byte content seen through the window after pointer wrap, the status field placement, the trigger thresholds for each code, and the exact tick on which the timeout fires and the events that clear it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    localparam int          ADDR_W      = 12;
    localparam int          ACK_W       = 10;
    localparam logic [9:0]  WA_STATUS   = 10'h000;
    localparam logic [9:0]  WA_ACK      = 10'h200;
    localparam logic [9:0]  WA_CONFIG   = 10'h202;
    localparam logic [9:0]  WA_TIMEOUT  = 10'h205;
    localparam int          CODE_LSB    = 20;
    localparam int          ST_OVR      = 0;
    localparam int          ST_RDA      = 1;
    localparam int          ST_CTI      = 2;
endpackage

// File: rtl/rxw_store.sv
module rxw_store #(
    parameter int PTR_W = 10
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [PTR_W-1:0] base_i,
    output logic [31:0]      word_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (wr_en_i) mem_q[wr_ptr_i] <= wr_data_i;
    end

    for (genvar j = 0; j < 4; j++) begin : g_lane
        assign word_o[8*j +: 8] = mem_q[base_i + PTR_W'(j)];
    end
endmodule

// File: rtl/rxw_level.sv
module rxw_level #(
    parameter int PTR_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             ack_en_i,
    input  logic [9:0]       ack_num_i,
    input  logic             ovr_clr_i,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic [PTR_W-1:0] count_o,
    output logic             accept_o,
    output logic             ovr_o
);
    localparam logic [PTR_W-1:0] CAP = {PTR_W{1'b1}};

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] cnt;
        logic             ovr;
    } lvl_t;

    lvl_t             s_q, s_d;
    logic [10:0]      cnt_ext, ack_ext;
    logic [PTR_W-1:0] rel;
    logic             acc;

    always_comb begin
        s_d     = s_q;
        cnt_ext = 11'(s_q.cnt);
        ack_ext = 11'(ack_num_i);
        rel     = '0;
        if (ack_en_i) rel = (ack_ext > cnt_ext) ? s_q.cnt : PTR_W'(ack_num_i);
        acc     = push_i && (s_q.cnt != CAP);
        s_d.rd  = s_q.rd + rel;
        s_d.cnt = s_q.cnt - rel + PTR_W'(acc);
        if (acc) s_d.wr = s_q.wr + PTR_W'(1);
        if (ovr_clr_i) s_d.ovr = 1'b0;
        if (push_i && !acc) s_d.ovr = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign wr_ptr_o = s_q.wr;
    assign rd_ptr_o = s_q.rd;
    assign count_o  = s_q.cnt;
    assign accept_o = acc;
    assign ovr_o    = s_q.ovr;
endmodule

// File: rtl/rxw_idle.sv
module rxw_idle #(
    parameter int TMO_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             armed_i,
    input  logic             restart_i,
    input  logic             clr_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             cti_o
);
    typedef struct packed {
        logic [TMO_W-1:0] idle;
        logic             cti;
    } idle_t;

    idle_t        s_q, s_d;
    logic [TMO_W:0] next_idle;

    always_comb begin
        s_d       = s_q;
        next_idle = {1'b0, s_q.idle} + (TMO_W+1)'(1);
        if (restart_i) begin
            s_d.idle = '0;
            s_d.cti  = 1'b0;
        end else begin
            if (clr_i) s_d.cti = 1'b0;
            if (!armed_i) begin
                s_d.idle = '0;
            end else if (tick_i && !s_q.cti && (limit_i != '0)) begin
                if (next_idle >= {1'b0, limit_i}) begin
                    s_d.cti  = 1'b1;
                    s_d.idle = '0;
                end else begin
                    s_d.idle = next_idle[TMO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cti_o = s_q.cti;
endmodule

// File: rtl/rx_window_fifo.sv
module rx_window_fifo
    import rxw_pkg::*;
#(
    parameter int DEPTH_LOG2 = 10,
    parameter int TMO_W      = 16
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        rx_valid_i,
    input  logic [7:0]  rx_data_i,
    input  logic        baud_tick_i,
    input  logic [11:0] bus_addr_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        rda_o,
    output logic        cti_o,
    output logic        ovr_o
);
    localparam int          PTR_W   = DEPTH_LOG2;
    localparam int          DEPTH   = 1 << PTR_W;
    localparam logic [11:0] WIN_END = 12'(DEPTH);

    typedef struct packed {
        logic [2:0]       code;
        logic [TMO_W-1:0] tmo;
        logic [31:0]      rdata;
    } top_t;

    top_t             s_q, s_d;
    logic [9:0]       waddr;
    logic             sel_status, sel_ack, sel_cfg, sel_tmo, sel_win;
    logic             ack_en, ovr_clr, cti_clr, accept, armed;
    logic [PTR_W-1:0] wr_ptr, rd_ptr, lvl_count, win_base;
    logic [10:0]      cnt_ext, thr;
    logic [9:0]       cnt10;
    logic [31:0]      win_word, status_word;

    assign waddr      = bus_addr_i[11:2];
    assign sel_status = (waddr == WA_STATUS);
    assign sel_ack    = (waddr == WA_ACK);
    assign sel_cfg    = (waddr == WA_CONFIG);
    assign sel_tmo    = (waddr == WA_TIMEOUT);
    assign sel_win    = (bus_addr_i >= 12'd4) && (bus_addr_i < WIN_END);

    assign ack_en  = bus_wr_i && sel_ack;
    assign ovr_clr = bus_wr_i && sel_status && bus_wdata_i[ST_OVR];
    assign cti_clr = bus_wr_i && sel_status && bus_wdata_i[ST_CTI];

    assign win_base = rd_ptr + PTR_W'(bus_addr_i & 12'hffc) - PTR_W'(4);

    rxw_level #(.PTR_W(PTR_W)) u_level (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .push_i    (rx_valid_i),
        .ack_en_i  (ack_en),
        .ack_num_i (bus_wdata_i[9:0]),
        .ovr_clr_i (ovr_clr),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .count_o   (lvl_count),
        .accept_o  (accept),
        .ovr_o     (ovr_o)
    );

    rxw_store #(.PTR_W(PTR_W)) u_store (
        .clk_i     (clk_i),
        .wr_en_i   (accept),
        .wr_ptr_i  (wr_ptr),
        .wr_data_i (rx_data_i),
        .base_i    (win_base),
        .word_o    (win_word)
    );

    assign cnt_ext = 11'(lvl_count);
    assign cnt10   = cnt_ext[9:0];
    assign thr     = 11'(4) << s_q.code;
    assign rda_o   = (cnt_ext >= thr);
    assign armed   = (lvl_count != '0) && (cnt_ext < thr);

    rxw_idle #(.TMO_W(TMO_W)) u_idle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (baud_tick_i),
        .armed_i   (armed),
        .restart_i (rx_valid_i || ack_en),
        .clr_i     (cti_clr),
        .limit_i   (s_q.tmo),
        .cti_o     (cti_o)
    );

    assign status_word = {cnt10[7:0], 16'h0000, cnt10[9:8], 3'b000, cti_o, rda_o, ovr_o};

    always_comb begin
        s_d = s_q;
        if (bus_wr_i && sel_cfg) s_d.code = bus_wdata_i[CODE_LSB +: 3];
        if (bus_wr_i && sel_tmo) s_d.tmo  = bus_wdata_i[TMO_W-1:0];
        if (bus_rd_i) begin
            if (sel_status)   s_d.rdata = status_word;
            else if (sel_win) s_d.rdata = win_word;
            else if (sel_cfg) s_d.rdata = 32'(s_q.code) << CODE_LSB;
            else if (sel_tmo) s_d.rdata = 32'(s_q.tmo);
            else              s_d.rdata = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign bus_rdata_o = s_q.rdata;
endmodule

// File: rtl/rx_window_fifo_chk.sv
module rx_window_fifo_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rx_valid_i,
    input logic             bus_wr_i,
    input logic [11:0]      bus_addr_i,
    input logic [31:0]      bus_wdata_i,
    input logic [PTR_W-1:0] count_i,
    input logic [2:0]       code_i,
    input logic             ovr_i,
    input logic             cti_i
);
    localparam logic [10:0] CAP = 11'((1 << PTR_W) - 1);

    logic [10:0] cnt, ackn, thr;
    logic        ack_wr, ovr_wr;

    assign cnt    = 11'(count_i);
    assign ackn   = 11'(bus_wdata_i[9:0]);
    assign thr    = 11'(4) << code_i;
    assign ack_wr = bus_wr_i && (bus_addr_i[11:2] == 10'h200);
    assign ovr_wr = bus_wr_i && (bus_addr_i[11:2] == 10'h000) && bus_wdata_i[0];

    AST_HOLD_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rx_valid_i && !ack_wr) |=> $stable(count_i)); // R2
    AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && !ack_wr && cnt != CAP) |=> (cnt == $past(cnt) + 11'd1)); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_wr && !rx_valid_i && ackn <= cnt) |=> (cnt == $past(cnt) - $past(ackn))); // R4
    AST_ACK_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_wr && !rx_valid_i && ackn >= cnt) |=> (cnt == 11'd0)); // R5
    AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_i && !ack_wr && cnt == CAP) |=> (cnt == CAP && ovr_i)); // R6
    AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovr_i && !ovr_wr) |=> ovr_i); // R6
    AST_CTI_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cti_i) |-> ($past(cnt) != 11'd0 && $past(cnt) < $past(thr))); // R8
endmodule

bind rx_window_fifo rx_window_fifo_chk #(.PTR_W(DEPTH_LOG2)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .count_i     (lvl_count),
    .code_i      (s_q.code),
    .ovr_i       (ovr_o),
    .cti_i       (cti_o)
);

// File: tb/rx_window_fifo_tb.sv
module rx_window_fifo_tb;
    localparam int DL   = 9;
    localparam int DEP  = 1 << DL;
    localparam int CAPB = DEP - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tick = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rda, cti, ovr;

    always #5 clk = ~clk;

    rx_window_fifo #(.DEPTH_LOG2(DL), .TMO_W(16)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
        .baud_tick_i(tick), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .rda_o(rda), .cti_o(cti), .ovr_o(ovr)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [7:0] m_mem [DEP];
    int m_rd = 0, m_cnt = 0, m_code = 0;
    bit m_ovr = 1'b0;
    int seed = 11;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = d;
        @(negedge clk); rx_valid = 1'b0;
        if (m_cnt < CAPB) begin
            m_mem[(m_rd + m_cnt) % DEP] = d;
            m_cnt++;
        end else m_ovr = 1'b1;
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic ack(input int n);
        int r;
        bwrite(12'h800, 32'(n));
        r = (n > m_cnt) ? m_cnt : n;
        m_rd = (m_rd + r) % DEP;
        m_cnt -= r;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(input bit c);
        logic [9:0] n;
        n = 10'(m_cnt);
        return {n[7:0], 16'h0, n[9:8], 3'b000, c, (m_cnt >= (4 << m_code)), m_ovr};
    endfunction

    task automatic check_status(input string req, input bit c);
        logic [31:0] s;
        bread(12'h000, s);
        chk(s == exp_status(c), req, s, exp_status(c));
    endtask

    task automatic check_window(input int words, input string req);
        logic [31:0] w;
        for (int m = 0; m < words; m++) begin
            bread(12'(4 + 4 * m), w);
            for (int j = 0; j < 4; j++) begin
                if (4 * m + j < m_cnt)
                    chk(w[8*j +: 8] == m_mem[(m_rd + 4 * m + j) % DEP], req,
                        w[8*j +: 8], m_mem[(m_rd + 4 * m + j) % DEP]);
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_status("R1", 1'b0);
        chk({rda, cti, ovr} == 3'b000, "R1", {rda, cti, ovr}, 0);
        bread(12'h808, v); chk(v == 0, "R1", v, 0);
        bread(12'h814, v); chk(v == 0, "R1", v, 0);

        // R2 count sweep with status field placement
        for (int i = 0; i < 40; i++) begin
            push(8'((i * 7 + 3) & 8'hff));
            check_status("R2", 1'b0);
        end
        // R3 window content
        check_window(12, "R3");
        // R4 acknowledge sweep
        for (int k = 1; k <= 6; k++) begin
            ack(k);
            check_status("R4", 1'b0);
            check_window(2, "R4");
        end
        // R2 upper count bits at 300 bytes
        while (m_cnt < 300) push(8'($urandom(seed) & 8'hff));
        check_status("R2", 1'b0);
        // R4 wrap the pointers round the store
        ack(290);
        for (int i = 0; i < 400; i++) push(8'((i * 13 + 1) & 8'hff));
        check_status("R4", 1'b0);
        check_window((DEP - 4) / 4, "R3");

        // R6 overrun at capacity
        while (m_cnt < CAPB) push(8'(m_cnt & 8'hff));
        chk(ovr == 1'b0, "R6", ovr, 0);
        for (int i = 0; i < 3; i++) push(8'hee);
        check_status("R6", 1'b0);
        chk(ovr == 1'b1, "R6", ovr, 1);
        check_window(8, "R6");
        ack(5);
        chk(ovr == 1'b1, "R6", ovr, 1);
        bwrite(12'h000, 32'h1); m_ovr = 1'b0;
        chk(ovr == 1'b0, "R6", ovr, 0);

        // R5 clamp
        ack(1023);
        check_status("R5", 1'b0);
        ack(7);
        check_status("R5", 1'b0);

        // R7 trigger thresholds and R10 readback
        for (int c = 0; c <= 6; c++) begin
            bwrite(12'h808, 32'(c) << 20); m_code = c;
            bread(12'h808, v); chk(v == (32'(c) << 20), "R10", v, 32'(c) << 20);
            while (m_cnt < (4 << c) - 1) push(8'(c));
            chk(rda == 1'b0, "R7", rda, 0);
            check_status("R7", 1'b0);
            push(8'(c));
            chk(rda == 1'b1, "R7", rda, 1);
            check_status("R7", 1'b0);
            ack(m_cnt);
            chk(rda == 1'b0, "R7", rda, 0);
        end

        // R8/R9 idle timeout, threshold 16
        bwrite(12'h808, 32'(2) << 20); m_code = 2;
        bwrite(12'h814, 32'd3);
        bread(12'h814, v); chk(v == 3, "R10", v, 3);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk(cti == 1'b0, "R8", cti, 0);
        push(8'h5a);
        pulse_tick(); pulse_tick();
        chk(cti == 1'b0, "R8", cti, 0);
        pulse_tick();
        chk(cti == 1'b1, "R8", cti, 1);
        check_status("R8", 1'b1);
        push(8'h5b);
        chk(cti == 1'b0, "R9", cti, 0);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk(cti == 1'b1, "R8", cti, 1);
        bwrite(12'h000, 32'h4);
        chk(cti == 1'b0, "R9", cti, 0);
        pulse_tick(); pulse_tick(); pulse_tick();
        chk(cti == 1'b1, "R8", cti, 1);
        ack(1);
        chk(cti == 1'b0, "R9", cti, 0);
        ack(m_cnt);
        bwrite(12'h814, 32'd0);
        push(8'h01);
        for (int i = 0; i < 8; i++) pulse_tick();
        chk(cti == 1'b0, "R8", cti, 0);
        bwrite(12'h814, 32'd3);
        while (m_cnt < 16) push(8'h02);
        for (int i = 0; i < 5; i++) pulse_tick();
        chk(cti == 1'b0, "R8", cti, 0);

        // R10 unmapped and beyond-window reads
        bread(12'(DEP), v); chk(v == 0, "R10", v, 0);
        bread(12'h900, v); chk(v == 0, "R10", v, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule